// File: doc/BRIEF.md
# Security Code Access Guard

This block decides whether a protected memory may be modified. It holds a two-byte secret code and an eight-bit attempt counter, and it grants a sticky write permit only after a correct verification sequence. A caller first spends one attempt by clearing a single still-set bit of the counter. It then compares the low code byte and after that the high code byte. The permit is raised only when both comparisons match within that attempt. The permit then holds until the next reset.

Each counter bit can be spent only once. After eight failed attempts the counter reads zero, and no later command can reach the granted state. The counter is refilled only by an explicit write issued while the permit is held. Reads of the code locations return zero until access is granted. Commands arrive one per cycle on a simple valid/opcode/address/data port. Read results return one cycle later.

The counter sits at address 1021. Code byte 1 sits at 1022 and code byte 2 at 1023, which are the top three addresses of a 10-bit space. The serial link and the array timing sit outside this block. The code and the counter live in internal registers that take their initial values at reset.

Top module: `seccode_guard`

## Requirements
- R1: After reset, write_permit is 0, a read of address 1021 returns 0xFF, and reads of 1022 and 1023 return 0x00.
- R2: Without the permit, a write (cmd_op = 2) to 1021 is accepted only if the data clears exactly one bit that is set in the counter and sets no bit. An accepted write stores the data and starts a new attempt. Any other write leaves the counter unchanged.
- R3: A compare (cmd_op = 3) of 1022 is evaluated only while an attempt is open. An attempt opens when a bit is spent and ends when any compare fails. A refused compare changes nothing.
- R4: write_permit rises only when a compare of 1022 matched and was followed, within the same attempt, by a matching compare of 1023. A compare of 1023 before byte 1 has matched, or a mismatch on either byte, ends the attempt. Spending another bit reopens the attempt from its start.
- R5: Once the counter reads 0x00 with no attempt open, no sequence of commands raises write_permit. Writes to the counter that would set bits are rejected.
- R6: A read (cmd_op = 1) sets rd_valid for one cycle in the next cycle. rd_data then shows the counter for 1021. It shows the code byte for 1022 or 1023 only while write_permit is 1, and 0x00 otherwise. It shows 0x00 for all other addresses.
- R7: The counter never gains a set bit except through a write to 1021 while write_permit is 1, which loads the written data (0xFF restores it). It is never refilled on its own.
- R8: While write_permit is 1, writes to 1022 and 1023 replace the code bytes. write_permit stays 1 until reset, whatever commands follow.
- R9: Without the permit, writes to 1022 and 1023 are ignored.
- R10: Code byte 1 (address 1022) is RESET_CODE[7:0] and code byte 2 (address 1023) is RESET_CODE[15:8]. Data bit 0 is the first bit of a byte on the serial line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 2 | 0 none, 1 read, 2 write, 3 compare |
| cmd_addr | input | ADDR_W | Target address |
| cmd_data | input | DATA_W | Write or compare data |
| rd_valid | output | 1 | Read result present |
| rd_data | output | DATA_W | Read result (masked view) |
| write_permit | output | 1 | Access granted; writes to the memory allowed |

## Verification
A corrupted attempt stage shows up in one of two ways at the ports. Either write_permit rises after an incomplete or out-of-order sequence, or it stays low after a correct one, and either one shows in the cycle after the second compare. A wrong counter update shows on the next read of 1021 as a value with a bit raised or with more than one bit cleared. A masking fault returns a code byte on the very next read while the permit is low. The lockout path is driven through all eight attempts and then probed with a correct code.

// File: rtl/seccode_pkg.sv
package seccode_pkg;

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_CMP   = 2'd3
  } sc_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_B1OK  = 2'd2,
    ST_GRANT = 2'd3
  } sc_stage_e;

  localparam int unsigned KEY_BYTES = 2;

endpackage

// File: rtl/seccode_errcnt.sv
module seccode_errcnt #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              granted,
  output logic [DATA_W-1:0] ec_q,
  output logic              consume_ok,
  output logic              exhausted
);

  logic [DATA_W-1:0] cleared;
  logic [DATA_W-1:0] raised;
  logic              single_clear;
  logic              restore;
  logic              ec_en;
  logic [DATA_W-1:0] ec_d;

  always_comb begin
    cleared      = ec_q & ~wr_data;
    raised       = wr_data & ~ec_q;
    single_clear = (cleared != '0) && ((cleared & (cleared - 1'b1)) == '0);
    consume_ok   = wr_en && !granted && single_clear && (raised == '0);
    restore      = wr_en && granted;
    ec_en        = consume_ok || restore;
    ec_d         = ec_q;
    if (ec_en) begin
      ec_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ec_q <= '1;
    end else if (ec_en) begin
      ec_q <= ec_d;
    end
  end

  assign exhausted = (ec_q == '0);

  AST_EC_SINGLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(granted) && (ec_q != $past(ec_q))) |->
      ($countones($past(ec_q)) == $countones(ec_q) + 1)); // R2

  AST_EC_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(granted) |-> ((ec_q & ~$past(ec_q)) == '0)); // R7

endmodule

// File: rtl/seccode_attempt.sv
module seccode_attempt
  import seccode_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic consume_ok,
  input  logic cmp1,
  input  logic cmp2,
  input  logic match1,
  input  logic match2,
  input  logic exhausted,
  output logic granted
);

  sc_stage_e stage_q;
  sc_stage_e stage_d;

  always_comb begin
    stage_d = stage_q;
    unique case (stage_q)
      ST_GRANT: stage_d = ST_GRANT;
      ST_IDLE: begin
        if (consume_ok) begin
          stage_d = ST_ARMED;
        end
      end
      ST_ARMED, ST_B1OK: begin
        if (consume_ok) begin
          stage_d = ST_ARMED;
        end else if (cmp1) begin
          stage_d = match1 ? ST_B1OK : ST_IDLE;
        end else if (cmp2) begin
          stage_d = (stage_q == ST_B1OK && match2) ? ST_GRANT : ST_IDLE;
        end
      end
      default: stage_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= ST_IDLE;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign granted = (stage_q == ST_GRANT);

  AST_GRANT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(granted) |-> granted); // R8

  AST_GRANT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(granted) |-> ($past(stage_q) == ST_B1OK && $past(cmp2) && $past(match2))); // R4

  AST_CMP_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == ST_IDLE && !consume_ok) |=> (stage_q != ST_B1OK && !granted)); // R3

  AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (exhausted && stage_q == ST_IDLE) |=> !granted); // R5

endmodule

// File: rtl/seccode_keybyte.sv
module seccode_keybyte #(
  parameter int unsigned       DATA_W   = 8,
  parameter logic [DATA_W-1:0] INIT_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] cmp_data,
  input  logic              granted,
  output logic [DATA_W-1:0] key_q,
  output logic              match
);

  logic [DATA_W-1:0] key_d;

  always_comb begin
    key_d = key_q;
    if (wr_en) begin
      key_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= INIT_VAL;
    end else if (wr_en) begin
      key_q <= key_d;
    end
  end

  assign match = (cmp_data == key_q);

  AST_KEY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(granted) |-> $stable(key_q)); // R9

endmodule

// File: rtl/seccode_readport.sv
module seccode_readport
  import seccode_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_en,
  input  logic                        sel_ec,
  input  logic [KEY_BYTES-1:0]        sel_key,
  input  logic                        granted,
  input  logic [DATA_W-1:0]           ec,
  input  logic [KEY_BYTES*DATA_W-1:0] keys,
  output logic                        rd_valid_q,
  output logic [DATA_W-1:0]           rd_data_q
);

  logic [DATA_W-1:0] view;

  always_comb begin
    view = '0;
    if (sel_ec) begin
      view = ec;
    end
    for (int k = 0; k < KEY_BYTES; k++) begin
      if (sel_key[k] && granted) begin
        view = keys[k*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_en;
      if (rd_en) begin
        rd_data_q <= view;
      end
    end
  end

  AST_KEY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_q && !$past(granted) && ($past(sel_key) != '0)) |-> (rd_data_q == '0)); // R6

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en) |-> rd_valid_q); // R6

endmodule

// File: rtl/seccode_guard.sv
module seccode_guard
  import seccode_pkg::*;
#(
  parameter int unsigned                    ADDR_W     = 10,
  parameter int unsigned                    DATA_W     = 8,
  parameter logic [KEY_BYTES*DATA_W-1:0]    RESET_CODE = 16'h5AC3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              write_permit
);

  localparam logic [ADDR_W-1:0] ADDR_TOP = '1;
  localparam logic [ADDR_W-1:0] EC_ADDR  = ADDR_TOP - ADDR_W'(KEY_BYTES);
  localparam logic [ADDR_W-1:0] KEY_BASE = EC_ADDR + 1'b1;

  logic [1:0] sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign core_rst_n = sync_q[1];

  sc_op_e                      op;
  logic                        do_rd;
  logic                        do_wr;
  logic                        do_cmp;
  logic                        sel_ec;
  logic [KEY_BYTES-1:0]        sel_key;
  logic [KEY_BYTES-1:0]        key_match;
  logic [KEY_BYTES*DATA_W-1:0] keys;
  logic [DATA_W-1:0]           ec;
  logic                        consume_ok;
  logic                        exhausted;
  logic                        granted;

  always_comb begin
    op     = sc_op_e'(cmd_op);
    do_rd  = cmd_valid && (op == OP_READ);
    do_wr  = cmd_valid && (op == OP_WRITE);
    do_cmp = cmd_valid && (op == OP_CMP);
    sel_ec = (cmd_addr == EC_ADDR);
  end

  seccode_errcnt #(.DATA_W(DATA_W)) u_errcnt (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .wr_en      (do_wr && sel_ec),
    .wr_data    (cmd_data),
    .granted    (granted),
    .ec_q       (ec),
    .consume_ok (consume_ok),
    .exhausted  (exhausted)
  );

  for (genvar i = 0; i < KEY_BYTES; i++) begin : g_key
    assign sel_key[i] = (cmd_addr == KEY_BASE + ADDR_W'(i));

    seccode_keybyte #(
      .DATA_W   (DATA_W),
      .INIT_VAL (RESET_CODE[i*DATA_W +: DATA_W])
    ) u_key (
      .clk      (clk),
      .rst_n    (core_rst_n),
      .wr_en    (do_wr && sel_key[i] && granted),
      .wr_data  (cmd_data),
      .cmp_data (cmd_data),
      .granted  (granted),
      .key_q    (keys[i*DATA_W +: DATA_W]),
      .match    (key_match[i])
    );
  end

  seccode_attempt u_attempt (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .consume_ok (consume_ok),
    .cmp1       (do_cmp && sel_key[0]),
    .cmp2       (do_cmp && sel_key[1]),
    .match1     (key_match[0]),
    .match2     (key_match[1]),
    .exhausted  (exhausted),
    .granted    (granted)
  );

  seccode_readport #(.DATA_W(DATA_W)) u_read (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .rd_en      (do_rd),
    .sel_ec     (sel_ec),
    .sel_key    (sel_key),
    .granted    (granted),
    .ec         (ec),
    .keys       (keys),
    .rd_valid_q (rd_valid),
    .rd_data_q  (rd_data)
  );

  assign write_permit = granted;

  AST_PERMIT_AFTER_RESET: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(core_rst_n) |-> !write_permit); // R1

endmodule

// File: tb/tb_seccode_guard.sv
module tb_seccode_guard;

  localparam logic [1:0] OPR = 2'd1;
  localparam logic [1:0] OPW = 2'd2;
  localparam logic [1:0] OPC = 2'd3;
  localparam logic [9:0] AEC = 10'd1021;
  localparam logic [9:0] AK1 = 10'd1022;
  localparam logic [9:0] AK2 = 10'd1023;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [1:0] cmd_op;
  logic [9:0] cmd_addr;
  logic [7:0] cmd_data;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       write_permit;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  seccode_guard dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_valid(rd_valid),
    .rd_data(rd_data), .write_permit(write_permit)
  );

  typedef struct packed {
    logic [1:0] op;
    logic [9:0] addr;
    logic [7:0] data;
    logic [7:0] exp;
    logic       chk;
    logic       perm;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t TBL [NV] = '{
    '{OPR, AEC, 8'h00, 8'hFF, 1'b1, 1'b0, 4'd1},  // R1
    '{OPR, AK1, 8'h00, 8'h00, 1'b1, 1'b0, 4'd1},  // R1
    '{OPR, AK2, 8'h00, 8'h00, 1'b1, 1'b0, 4'd6},  // R6
    '{OPC, AK1, 8'hC3, 8'h00, 1'b0, 1'b0, 4'd3},  // R3 not armed
    '{OPC, AK2, 8'h5A, 8'h00, 1'b0, 1'b0, 4'd3},  // R3
    '{OPW, AEC, 8'hFC, 8'h00, 1'b0, 1'b0, 4'd2},  // R2 two bits
    '{OPR, AEC, 8'h00, 8'hFF, 1'b1, 1'b0, 4'd2},  // R2
    '{OPW, AEC, 8'hFE, 8'h00, 1'b0, 1'b0, 4'd2},  // R2 accepted
    '{OPR, AEC, 8'h00, 8'hFE, 1'b1, 1'b0, 4'd2},  // R2
    '{OPW, AEC, 8'hFD, 8'h00, 1'b0, 1'b0, 4'd2},  // R2 raises bit 0
    '{OPR, AEC, 8'h00, 8'hFE, 1'b1, 1'b0, 4'd2},  // R2
    '{OPC, AK2, 8'h5A, 8'h00, 1'b0, 1'b0, 4'd4},  // R4 out of order
    '{OPC, AK1, 8'hC3, 8'h00, 1'b0, 1'b0, 4'd3},  // R3 attempt ended
    '{OPC, AK2, 8'h5A, 8'h00, 1'b0, 1'b0, 4'd4},  // R4
    '{OPW, AEC, 8'hFC, 8'h00, 1'b0, 1'b0, 4'd2},  // R2
    '{OPC, AK1, 8'h00, 8'h00, 1'b0, 1'b0, 4'd4},  // R4 mismatch
    '{OPC, AK2, 8'h5A, 8'h00, 1'b0, 1'b0, 4'd4},  // R4
    '{OPW, AK1, 8'h11, 8'h00, 1'b0, 1'b0, 4'd9},  // R9 ignored
    '{OPW, AEC, 8'hF8, 8'h00, 1'b0, 1'b0, 4'd2},  // R2
    '{OPC, AK1, 8'hC3, 8'h00, 1'b0, 1'b0, 4'd4},  // R4
    '{OPC, AK2, 8'h5A, 8'h00, 1'b0, 1'b1, 4'd4},  // R4 granted
    '{OPR, AK1, 8'h00, 8'hC3, 1'b1, 1'b1, 4'd9},  // R9 R10
    '{OPR, AK2, 8'h00, 8'h5A, 1'b1, 1'b1, 4'd10}, // R10
    '{OPR, AEC, 8'h00, 8'hF8, 1'b1, 1'b1, 4'd7},  // R7 no auto restore
    '{OPW, AEC, 8'hFF, 8'h00, 1'b0, 1'b1, 4'd7},  // R7
    '{OPR, AEC, 8'h00, 8'hFF, 1'b1, 1'b1, 4'd7},  // R7
    '{OPW, AK1, 8'h3C, 8'h00, 1'b0, 1'b1, 4'd8},  // R8
    '{OPR, AK1, 8'h00, 8'h3C, 1'b1, 1'b1, 4'd8},  // R8
    '{OPC, AK1, 8'h00, 8'h00, 1'b0, 1'b1, 4'd8},  // R8 permit stays
    '{OPR, 10'd0, 8'h00, 8'h00, 1'b1, 1'b1, 4'd6} // R6 other address
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [9:0] addr, input logic [7:0] data);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_addr  = addr;
    cmd_data  = data;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = 2'd0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] cur;
    cmd_valid = 1'b0;
    cmd_op    = 2'd0;
    cmd_addr  = '0;
    cmd_data  = '0;
    do_reset();
    check("R1 permit", {7'd0, write_permit}, 8'h00);
    check("R1 rd_valid", {7'd0, rd_valid}, 8'h00);

    for (int v = 0; v < NV; v++) begin
      do_cmd(TBL[v].op, TBL[v].addr, TBL[v].data);
      check($sformatf("R%0d permit v%0d", TBL[v].req, v), {7'd0, write_permit}, {7'd0, TBL[v].perm});
      check($sformatf("R%0d rd_valid v%0d", TBL[v].req, v), {7'd0, rd_valid}, {7'd0, TBL[v].chk});
      if (TBL[v].chk) begin
        check($sformatf("R%0d rd_data v%0d", TBL[v].req, v), rd_data, TBL[v].exp);
      end
    end

    // R8: permit held through further commands
    do_cmd(OPW, AEC, 8'h00);
    do_cmd(OPC, AK2, 8'h00);
    check("R8 permit sticky", {7'd0, write_permit}, 8'h01);

    // R4: spending a new bit restarts the attempt after byte 1 matched
    do_reset();
    check("R1 permit after reset", {7'd0, write_permit}, 8'h00);
    do_cmd(OPR, AK1, 8'h00);
    check("R1 key masked after reset", rd_data, 8'h00);
    do_cmd(OPW, AEC, 8'h7F);
    do_cmd(OPC, AK1, 8'hC3);
    do_cmd(OPW, AEC, 8'h3F);
    do_cmd(OPC, AK2, 8'h5A);
    check("R4 restart drops byte1", {7'd0, write_permit}, 8'h00);

    // R5: eight failed attempts lock the guard
    do_reset();
    cur = 8'hFF;
    for (int i = 0; i < 8; i++) begin
      cur = cur & ~(8'h01 << i);
      do_cmd(OPW, AEC, cur);
      do_cmd(OPC, AK1, 8'h00);
    end
    do_cmd(OPR, AEC, 8'h00);
    check("R5 counter empty", rd_data, 8'h00);
    do_cmd(OPW, AEC, 8'hFF);
    do_cmd(OPR, AEC, 8'h00);
    check("R5 refill refused", rd_data, 8'h00);
    do_cmd(OPC, AK1, 8'hC3);
    do_cmd(OPC, AK2, 8'h5A);
    check("R5 locked no permit", {7'd0, write_permit}, 8'h00);
    do_cmd(OPR, AK2, 8'h00);
    check("R6 key masked when locked", rd_data, 8'h00);

    summary();
  end

endmodule